// File: doc/BRIEF.md
# GPIO Port Data Register

This block is the data register of a thirteen-pin general-purpose I/O port, reached over a 16-bit bus. Each pin has its own 2-bit mode field, supplied from outside the block. The mode decides two things for that pin: where a bus read of its bit comes from, and whether the block drives the pin.

A pin in output mode is driven from its stored data bit, and a read of that bit returns the stored bit. A pin in input mode or in alternate-function mode reads back the pin level after a two-flop synchronizer. A pin in the reserved mode reads as zero and is never driven. A bus write always updates the stored bits it selects, whatever mode each pin is in.

The block has two reset inputs. A power-on reset clears the stored data. A manual reset, like the low-power hold, leaves the stored data as it was. Both resets clear the synchronizer and release all output enables.

Top module: `gpio_port_data`

## Requirements
- R1: After a power-on reset the 13 stored data bits are all 0, and this is visible on `pin_out` and on reads of pins in output mode.
- R2: Read bits 15..13 are always 0, and write data in bits 15..13 is ignored.
- R3: While `man_rst` is high, the stored data holds its value and write strobes are ignored. During the cycle after any cycle with `man_rst` high, `pin_oe` is 0.
- R4: While `lp_hold` is high, the stored data holds its value and write strobes are ignored.
- R5: For a pin with mode 00 (input), the read bit equals the pin level sampled two rising edges earlier. `pin_oe` for that pin is 0.
- R6: For a pin with mode 01 (output), the read bit equals the stored bit and `pin_out` equals the stored bit. `pin_oe` goes to 1 one cycle after the mode is applied.
- R7: For a pin with mode 11 (alternate function), the read bit is the synchronized pin level and `pin_oe` is 0.
- R8: For a pin with mode 10 (reserved), the read bit is 0 and `pin_oe` is 0.
- R9: A write (`bus_we` high, both reset inputs and `lp_hold` low) updates the stored bit at the next rising edge, whatever the pin's mode.
- R10: A write changes only the bits whose `bus_wmask` bit is 1. The mask is one bit per data bit: bit n enables data bit n.
- R11: When `por_rst` and `man_rst` are both high, the power-on reset wins and the stored data is cleared.
- R12: Power-on reset clears the synchronizer and all output enables, so right after it, input-mode reads are 0 and no pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset; clears the data |
| man_rst | input | 1 | Synchronous active-high manual reset; keeps the data |
| lp_hold | input | 1 | Low-power hold; freezes the data |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_wmask | input | 16 | Per-bit write enable |
| bus_rdata | output | 16 | Combinational read data |
| pin_mode | input | 26 | Two bits per pin; pin n uses bits [2n+1:2n] |
| pin_in | input | 13 | Pin levels, asynchronous |
| pin_out | output | 13 | Value driven on each pin |
| pin_oe | output | 13 | Registered output enable for each pin |

## Verification
The hardest case to reach is a stored bit written while its pin was not in output mode. That value cannot be read back until the pin's mode changes. The stimulus therefore writes patterns under input, reserved and alternate modes, and under a held manual reset or low-power hold. It then switches every pin to output mode and compares the read value with a model of the stored data. Separate sweeps apply uniform and mixed per-pin modes across many pin patterns, and step the pin level once to measure the two-edge synchronizer delay.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_IN   = 2'b00,
    PM_OUT  = 2'b01,
    PM_RSVD = 2'b10,
    PM_ALT  = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int NPINS = 13,
  parameter int BUSW  = 16
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             hold,
  input  logic             we,
  input  logic [BUSW-1:0]  wdata,
  input  logic [BUSW-1:0]  wmask,
  output logic [NPINS-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (por_rst) begin
      data_q <= '0;
    end else if (we && !hold) begin
      for (int b = 0; b < NPINS; b++)
        if (wmask[b]) data_q[b] <= wdata[b];
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 13,
  parameter int BUSW  = 16
) (
  input  logic               clk,
  input  logic               oe_clr,
  input  logic [2*NPINS-1:0] mode,
  input  logic [NPINS-1:0]   data_q,
  input  logic [NPINS-1:0]   pin_sync,
  output logic [BUSW-1:0]    rdata,
  output logic [NPINS-1:0]   oe_q
);
  logic [NPINS-1:0] rd_bit;
  logic [NPINS-1:0] oe_nxt;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    pin_mode_e m;
    assign m = pin_mode_e'(mode[2*n +: 2]);
    always_comb begin
      unique case (m)
        PM_OUT:  rd_bit[n] = data_q[n];
        PM_RSVD: rd_bit[n] = 1'b0;
        default: rd_bit[n] = pin_sync[n];
      endcase
    end
    assign oe_nxt[n] = (m == PM_OUT);
  end

  always_ff @(posedge clk) begin
    if (oe_clr) oe_q <= '0;
    else        oe_q <= oe_nxt;
  end

  if (BUSW > NPINS) begin : g_pad
    assign rdata = {{(BUSW-NPINS){1'b0}}, rd_bit};
  end else begin : g_nopad
    assign rdata = rd_bit[BUSW-1:0];
  end
endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data #(
  parameter int NPINS       = 13,
  parameter int BUSW        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_rst,
  input  logic               man_rst,
  input  logic               lp_hold,
  input  logic               bus_we,
  input  logic [BUSW-1:0]    bus_wdata,
  input  logic [BUSW-1:0]    bus_wmask,
  output logic [BUSW-1:0]    bus_rdata,
  input  logic [2*NPINS-1:0] pin_mode,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe
);
  localparam int MW = 2 * NPINS;

  logic             any_rst;
  logic             data_hold;
  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] pin_sync;

  assign any_rst   = por_rst | man_rst;
  assign data_hold = man_rst | lp_hold;

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .clr (any_rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_data_reg #(.NPINS(NPINS), .BUSW(BUSW)) u_reg (
    .clk     (clk),
    .por_rst (por_rst),
    .hold    (data_hold),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .wmask   (bus_wmask),
    .data_q  (data_q)
  );

  gpio_pin_mux #(.NPINS(NPINS), .BUSW(BUSW)) u_mux (
    .clk      (clk),
    .oe_clr   (any_rst),
    .mode     (pin_mode[MW-1:0]),
    .data_q   (data_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata),
    .oe_q     (pin_oe)
  );

  assign pin_out = data_q;
endmodule

// File: rtl/gpio_port_data_chk.sv
module gpio_port_data_chk #(
  parameter int NPINS = 13,
  parameter int BUSW  = 16
) (
  input logic               clk,
  input logic               por_rst,
  input logic               man_rst,
  input logic               lp_hold,
  input logic               bus_we,
  input logic [BUSW-1:0]    bus_wdata,
  input logic [BUSW-1:0]    bus_wmask,
  input logic [BUSW-1:0]    bus_rdata,
  input logic [2*NPINS-1:0] pin_mode,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pin_oe
);
  logic [NPINS-1:0] want_oe;
  logic [NPINS-1:0] rsvd_pins;
  always_comb begin
    for (int n = 0; n < NPINS; n++) begin
      want_oe[n]   = (pin_mode[2*n +: 2] == 2'b01);
      rsvd_pins[n] = (pin_mode[2*n +: 2] == 2'b10);
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (por_rst)
    bus_rdata[BUSW-1:NPINS] == '0);

  a_r11_por_clears: assert property (@(posedge clk)
    por_rst |=> pin_out == '0);

  a_r3_manrst_holds: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> $stable(pin_out));

  a_r3_manrst_oe_off: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> pin_oe == '0);

  a_r4_lp_holds: assert property (@(posedge clk) disable iff (por_rst)
    lp_hold |=> $stable(pin_out));

  a_r6_oe_follows_mode: assert property (@(posedge clk) disable iff (por_rst || man_rst)
    1'b1 |=> pin_oe == $past(want_oe));

  a_r8_rsvd_reads_zero: assert property (@(posedge clk) disable iff (por_rst)
    (bus_rdata[NPINS-1:0] & rsvd_pins) == '0);

  a_r10_masked_write: assert property (@(posedge clk) disable iff (por_rst)
    (!bus_we || man_rst || lp_hold) |=> $stable(pin_out));
endmodule

bind gpio_port_data gpio_port_data_chk #(.NPINS(NPINS), .BUSW(BUSW)) u_chk (
  .clk       (clk),
  .por_rst   (por_rst),
  .man_rst   (man_rst),
  .lp_hold   (lp_hold),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_wmask (bus_wmask),
  .bus_rdata (bus_rdata),
  .pin_mode  (pin_mode),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_port_data.sv
module sim_gpio_port_data;
  localparam int NP = 13;
  localparam logic [NP-1:0] ALL = '1;

  logic clk = 1'b0;
  logic por_rst = 1'b1, man_rst = 1'b0, lp_hold = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_wdata = '0, bus_wmask = '0;
  logic [15:0] bus_rdata;
  logic [2*NP-1:0] pin_mode = '0;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;

  int vectors = 0, errs = 0;
  logic [NP-1:0] model = '0;

  always #10 clk = ~clk;

  gpio_port_data u0 (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .lp_hold(lp_hold),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(bus_rdata), .pin_mode(pin_mode), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2*NP-1:0] all_mode(logic [1:0] m);
    logic [2*NP-1:0] r;
    for (int n = 0; n < NP; n++) r[2*n +: 2] = m;
    return r;
  endfunction

  function automatic logic [15:0] exp_read(logic [2*NP-1:0] md, logic [NP-1:0] pins);
    logic [15:0] r = '0;
    for (int n = 0; n < NP; n++)
      case (md[2*n +: 2])
        2'b01:   r[n] = model[n];
        2'b10:   r[n] = 1'b0;
        default: r[n] = pins[n];
      endcase
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_oe(logic [2*NP-1:0] md);
    logic [NP-1:0] r;
    for (int n = 0; n < NP; n++) r[n] = (md[2*n +: 2] == 2'b01);
    return r;
  endfunction

  task automatic wr(logic [15:0] d, logic [15:0] m);
    bus_we = 1'b1; bus_wdata = d; bus_wmask = m;
    tick();
    bus_we = 1'b0;
    if (!man_rst && !lp_hold && !por_rst)
      model = (model & ~m[NP-1:0]) | (d[NP-1:0] & m[NP-1:0]);
  endtask

  initial begin
    #3_000_000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    @(negedge clk);
    pin_in = ALL;
    tick(3);
    por_rst = 1'b0;
    // R12: synchronizer and enables cleared by power-on reset
    chk("R12 rdata", bus_rdata, 16'h0);
    chk("R12 oe", {3'b0, pin_oe}, 16'h0);
    pin_in = '0;
    pin_mode = all_mode(2'b01);
    tick();
    chk("R6 oe", {3'b0, pin_oe}, {3'b0, ALL});
    chk("R1 rdata", bus_rdata, 16'h0);
    chk("R1 pin_out", {3'b0, pin_out}, 16'h0);

    // R9/R10/R2: write sweep in output mode
    for (int i = 0; i < 64; i++) begin
      logic [15:0] d, m;
      d = 16'(i * 16'h1F3B) ^ 16'(i << 7) ^ 16'hE000;
      m = (i % 8 == 0) ? 16'hFFFF : ~16'(i * 16'h0D55);
      wr(d, m);
      chk("R10 rdata", bus_rdata, {3'b0, model});
      chk("R6 pin_out", {3'b0, pin_out}, {3'b0, model});
      chk("R2 upper", {13'b0, bus_rdata[15:13]}, 16'h0);
    end

    // R5/R6/R7/R8: uniform mode sweep
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [NP-1:0] pat;
        pat = NP'(p * 13'h0A57) ^ NP'(p << 9);
        pin_mode = all_mode(2'(m));
        pin_in = pat;
        tick(2);
        chk(m == 0 ? "R5 read" : m == 1 ? "R6 read" : m == 2 ? "R8 read" : "R7 read",
            bus_rdata, exp_read(pin_mode, pat));
        chk("R8 oe", {3'b0, pin_oe}, {3'b0, exp_oe(pin_mode)});
      end
    end

    // mixed per-pin modes
    for (int k = 0; k < 8; k++) begin
      logic [NP-1:0] pat;
      for (int n = 0; n < NP; n++) pin_mode[2*n +: 2] = 2'((n + k) % 4);
      pat = NP'(k * 13'h0B6D) ^ 13'h1555;
      pin_in = pat;
      tick(2);
      chk("R7 mixed read", bus_rdata, exp_read(pin_mode, pat));
      chk("R6 mixed oe", {3'b0, pin_oe}, {3'b0, exp_oe(pin_mode)});
    end

    // R5: two-edge synchronizer latency
    pin_mode = all_mode(2'b00);
    pin_in = '0;
    tick(3);
    pin_in = ALL;
    tick();
    chk("R5 one edge", bus_rdata, 16'h0);
    tick();
    chk("R5 two edges", bus_rdata, {3'b0, ALL});

    // R9: writes under non-output modes land in storage
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      pin_mode = all_mode(2'(m));
      tick();
      wr(16'h1234 ^ 16'(m * 16'h0F0F), 16'hFFFF);
      chk("R9 oe off", {3'b0, pin_oe}, 16'h0);
      pin_mode = all_mode(2'b01);
      tick();
      chk("R9 readback", bus_rdata, {3'b0, model});
    end

    // R3: manual reset keeps data and blocks writes
    man_rst = 1'b1;
    wr(16'h0ACE, 16'hFFFF);
    chk("R3 oe", {3'b0, pin_oe}, 16'h0);
    tick(2);
    man_rst = 1'b0;
    tick();
    chk("R3 data kept", bus_rdata, {3'b0, model});

    // R4: low-power hold blocks writes
    lp_hold = 1'b1;
    wr(~{3'b0, model}, 16'hFFFF);
    tick(2);
    chk("R4 hold out", {3'b0, pin_out}, {3'b0, model});
    lp_hold = 1'b0;
    chk("R4 data kept", bus_rdata, {3'b0, model});

    // R11: power-on reset wins over manual reset
    wr(16'h1FFF, 16'hFFFF);
    por_rst = 1'b1; man_rst = 1'b1;
    tick();
    por_rst = 1'b0; man_rst = 1'b0;
    model = '0;
    tick();
    chk("R11 cleared", bus_rdata, 16'h0);
    chk("R1 pin_out", {3'b0, pin_out}, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule